// File: doc/BRIEF.md
# Flash reset and ready/busy sequencer

This block sits between a flash device's external reset pin and its internal program/erase controller. It samples the asynchronous reset pin through a synchronizer and treats a low level as a hardware reset only after it has lasted a minimum number of clock cycles. If the controller is running a program or erase at that moment, the block asks it to abort and waits for the abort to finish. Once the pin is high again it holds off bus traffic until two recovery intervals have both run out.

The ready/busy line is open-drain. The block therefore produces a drive-low enable, never a level. During normal operation the enable follows the controller's state: it is asserted while a program or erase runs and released in read, auto-select and erase-suspend modes. During a reset it stays asserted for as long as an abort is in progress. After power-up the block starts in the normal read state with bus access allowed.

Top module: `rstrdy_seq`

## Requirements
- R1: After the system reset is released, the block is in the normal state: `bus_allow`=1, `ctl_hold`=0, `abort_req`=0 and `busy_pull_en`=0 with the controller idle.
- R2: The reset pin passes through `SYNC_STAGES` flip-flops. A reset is recognised only after the synchronized pin has been sampled low on `MIN_LOW_CYC` consecutive clock edges. A shorter low pulse leaves `bus_allow` at 1.
- R3: A reset recognised while `op_run`=0 drops `bus_allow`, raises `ctl_hold` and leaves `abort_req` at 0.
- R4: A reset recognised while `op_run`=1 raises `abort_req`. `abort_req` and `busy_pull_en` then stay at 1 until `abort_done` is sampled high, and recovery starts on the following cycle.
- R5: The pin-recovery interval counts `PIN_REC_CYC` edges on which the synchronized pin is high while the block is out of its normal state. Any low sample restarts the count.
- R6: The ready-recovery interval counts `RDY_REC_CYC` edges from the point where the busy line was released and recovery began. `bus_allow` returns to 1 one cycle after both intervals have completed, whichever completes later.
- R7: In the normal state, `busy_pull_en`=1 (pull the shared line low) exactly when `op_run`=1 and `op_susp`=0. With `op_susp`=1 the line is released. The block never drives the line high.
- R8: `abort_done` has no effect outside an abort: a pulse in the normal state leaves `bus_allow`=1 and `abort_req`=0.
- R9: `ctl_hold` is the inverse of `bus_allow` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, asynchronous assert, active low |
| rst_pin_n | input | 1 | Device hardware-reset pin, asynchronous, active low |
| op_run | input | 1 | Controller is executing a program or erase |
| op_susp | input | 1 | Running erase is suspended |
| abort_done | input | 1 | Controller has finished aborting |
| busy_pull_en | output | 1 | Open-drain enable: 1 pulls ready/busy low |
| abort_req | output | 1 | Request to abort the running operation |
| ctl_hold | output | 1 | Hold the controller in its reset/read state |
| bus_allow | output | 1 | Bus reads and writes may proceed |

## Verification
The bench sends a low pulse one cycle shorter than the qualifying time. A design with an off-by-one qualifier would drop bus access on that pulse. It glitches the pin during recovery: a design that failed to restart the pin interval would release the bus early. It also keeps an abort running long after the pin has risen, so the ready interval is the one that decides the release. A design that timed only from the pin edge, or that released busy before `abort_done`, would open the bus too soon. A stray `abort_done` pulse in normal operation must change nothing.

// File: rtl/rstrdy_pkg.sv
package rstrdy_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_ABORT = 2'd1,
    SEQ_RECOV = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rstrdy_sync.sv
module rstrdy_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= d;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rstrdy_satcnt.sv
module rstrdy_satcnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);

  localparam int unsigned W   = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | (cnt_q != LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (cnt_q != LIM)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);

  // R5
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done);

endmodule

// File: rtl/rstrdy_seq.sv
module rstrdy_seq
  import rstrdy_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW_CYC = 500,
  parameter int unsigned PIN_REC_CYC = 2000,
  parameter int unsigned RDY_REC_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic op_run,
  input  logic op_susp,
  input  logic abort_done,
  output logic busy_pull_en,
  output logic abort_req,
  output logic ctl_hold,
  output logic bus_allow
);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       pin_s;
  logic       low_qual;
  logic       pin_done;
  logic       rdy_done;
  logic       in_run;
  logic       in_abort;
  logic       in_recov;

  rstrdy_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rst_pin_n),
    .q     (pin_s)
  );

  rstrdy_satcnt #(.LIMIT(MIN_LOW_CYC)) u_low_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pin_s),
    .done  (low_qual)
  );

  rstrdy_satcnt #(.LIMIT(PIN_REC_CYC)) u_pin_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (in_run | ~pin_s),
    .done  (pin_done)
  );

  rstrdy_satcnt #(.LIMIT(RDY_REC_CYC)) u_rdy_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~in_recov),
    .done  (rdy_done)
  );

  assign in_run   = (state_q == SEQ_RUN);
  assign in_abort = (state_q == SEQ_ABORT);
  assign in_recov = (state_q == SEQ_RECOV);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_RUN: begin
        if (low_qual) state_d = op_run ? SEQ_ABORT : SEQ_RECOV;
      end
      SEQ_ABORT: begin
        if (abort_done) state_d = SEQ_RECOV;
      end
      SEQ_RECOV: begin
        if (pin_s && pin_done && rdy_done) state_d = SEQ_RUN;
      end
      default: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_RUN;
    else        state_q <= state_d;
  end

  assign busy_pull_en = in_abort | (in_run & op_run & ~op_susp);
  assign abort_req    = in_abort;
  assign ctl_hold     = ~in_run;
  assign bus_allow    = in_run;

  // R2 R3
  fall_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_allow) |-> $past(low_qual));

  // R6
  rise_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_allow) |-> $past(pin_done && rdy_done && pin_s));

  // R4
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !abort_done) |=> abort_req);

  // R4
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_req) |-> $past(abort_done));

endmodule

// File: tb/rstrdy_seq_bench.sv
module rstrdy_seq_bench;

  localparam int CLK_PER = 10;
  localparam int SYNC    = 2;
  localparam int MINL    = 4;
  localparam int RA      = 10;
  localparam int RB      = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic rst_pin_n;
  logic op_run;
  logic op_susp;
  logic abort_done;
  logic busy_pull_en;
  logic abort_req;
  logic ctl_hold;
  logic bus_allow;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  rstrdy_seq #(
    .SYNC_STAGES (SYNC),
    .MIN_LOW_CYC (MINL),
    .PIN_REC_CYC (RA),
    .RDY_REC_CYC (RB)
  ) u_rstrdy_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_pin_n    (rst_pin_n),
    .op_run       (op_run),
    .op_susp      (op_susp),
    .abort_done   (abort_done),
    .busy_pull_en (busy_pull_en),
    .abort_req    (abort_req),
    .ctl_hold     (ctl_hold),
    .bus_allow    (bus_allow)
  );

  // behavioural reference: 0 normal, 1 aborting, 2 recovering
  int m_st, m_low, m_ca, m_cb;
  bit m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_low = 0; m_ca = 0; m_cb = 0;
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back(1'b1);
    end else begin
      bit p;
      int nst, nlow, nca, ncb;
      p   = m_q[0];
      nst = m_st;
      if (m_st == 0 && m_low == MINL) nst = op_run ? 1 : 2;
      else if (m_st == 1 && abort_done) nst = 2;
      else if (m_st == 2 && p && m_ca == RA && m_cb == RB) nst = 0;
      nlow = p ? 0 : ((m_low < MINL) ? m_low + 1 : m_low);
      nca  = (m_st == 0 || !p) ? 0 : ((m_ca < RA) ? m_ca + 1 : m_ca);
      ncb  = (m_st == 2) ? ((m_cb < RB) ? m_cb + 1 : m_cb) : 0;
      m_st = nst; m_low = nlow; m_ca = nca; m_cb = ncb;
      m_q.push_back(rst_pin_n);
      void'(m_q.pop_front());
    end
  end

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n) begin
      expect_bit("R4 abort_req vs model", abort_req, m_st == 1);
      expect_bit("R7 R4 busy_pull_en vs model", busy_pull_en,
                 (m_st == 1) || (m_st == 0 && op_run && !op_susp));
      expect_bit("R5 R6 bus_allow vs model", bus_allow, m_st == 0);
      expect_bit("R9 ctl_hold vs model", ctl_hold, m_st != 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rst_pin_n = 1'b1; op_run = 1'b0; op_susp = 1'b0; abort_done = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_bit("R1 bus_allow", bus_allow, 1'b1);
    expect_bit("R1 ctl_hold", ctl_hold, 1'b0);
    expect_bit("R1 abort_req", abort_req, 1'b0);
    expect_bit("R1 busy_pull_en", busy_pull_en, 1'b0);

    op_run = 1'b1;
    step(1);
    expect_bit("R7 busy while running", busy_pull_en, 1'b1);
    op_susp = 1'b1;
    step(1);
    expect_bit("R7 released in suspend", busy_pull_en, 1'b0);
    op_run = 1'b0; op_susp = 1'b0;
    step(2);

    // R2: pulse one cycle short of qualifying
    rst_pin_n = 1'b0; step(MINL - 1); rst_pin_n = 1'b1;
    step(12);
    expect_bit("R2 short pulse ignored", bus_allow, 1'b1);

    // R3: qualifying pulse with controller idle
    rst_pin_n = 1'b0; step(MINL); rst_pin_n = 1'b1;
    step(4);
    expect_bit("R3 bus blocked", bus_allow, 1'b0);
    expect_bit("R3 no abort", abort_req, 1'b0);
    expect_bit("R3 hold raised", ctl_hold, 1'b1);
    step(30);
    expect_bit("R6 bus reopened", bus_allow, 1'b1);

    // R5: glitch during recovery restarts pin interval
    rst_pin_n = 1'b0; step(5); rst_pin_n = 1'b1;
    step(8);
    rst_pin_n = 1'b0; step(2); rst_pin_n = 1'b1;
    step(8);
    expect_bit("R5 glitch restarts interval", bus_allow, 1'b0);
    step(30);
    expect_bit("R5 reopened after glitch", bus_allow, 1'b1);

    // R4: reset during an operation, long abort
    op_run = 1'b1;
    rst_pin_n = 1'b0; step(6); rst_pin_n = 1'b1;
    for (int i = 0; i < 50 && !abort_req; i++) step(1);
    expect_bit("R4 abort requested", abort_req, 1'b1);
    step(20);
    expect_bit("R4 abort held", abort_req, 1'b1);
    expect_bit("R4 busy held low", busy_pull_en, 1'b1);
    expect_bit("R4 bus blocked in abort", bus_allow, 1'b0);
    abort_done = 1'b1; op_run = 1'b0;
    step(1);
    abort_done = 1'b0;
    step(2);
    expect_bit("R4 busy released after abort", busy_pull_en, 1'b0);
    expect_bit("R6 ready interval pending", bus_allow, 1'b0);
    step(10);
    expect_bit("R6 reopened after ready interval", bus_allow, 1'b1);

    // R8: stray abort_done in normal state
    abort_done = 1'b1; step(1); abort_done = 1'b0;
    step(3);
    expect_bit("R8 stray done ignored", bus_allow, 1'b1);
    expect_bit("R8 no abort", abort_req, 1'b0);

    step(5);
    finish_run();
  end

endmodule